// File: doc/BRIEF.md
# Oversampled SPI Slave Interface

This block is the slave side of a serial peripheral link. It runs entirely on the system clock and treats the external serial clock, data-in and active-low select lines as slow asynchronous signals. Each line is resynchronised and edge-detected, so the serial clock must run at no more than one eighth of the system clock. Polarity and phase inputs select any of the four standard clocking modes. A width input selects 8-bit or 16-bit characters.

One shift register serves both directions, most significant bit first. Each incoming bit enters at the bottom while the top bit is presented on the outgoing data line. Software loads the next outgoing character through a write strobe, which is honoured only while the slave is deselected. If software loads nothing, the slave sends back whatever the register holds, which is the character it last received.

When a full character arrives, it is copied to a read buffer and a sticky completion flag is raised. The flag drives an interrupt request through an enable. If the master deselects the slave part-way through a character, the slave discards the partial character and resets its bit counter.

Top module: `spi_slv_core`

## Requirements
- R1: After reset, `miso_oe`, `done_flag` and `irq` are 0 and `rd_buf` is 0.
- R2: While `ssn_in` is high, `miso_oe` is 0, and activity on `sclk_in` and `mosi_in` changes neither `rd_buf` nor `done_flag`.
- R3: Transfers are full duplex and MSB first. In a transfer, the master receives the loaded character on `miso_o`, highest used bit first. The master's character appears in `rd_buf` when the transfer completes.
- R4: The clocking mode is set by `cfg_cpol` and `cfg_cpha`, giving all four modes. The idle clock level equals `cfg_cpol`. With `cfg_cpha`=0, data is sampled on the leading edge, and the first bit is valid once select goes low. With `cfg_cpha`=1, data is driven on the leading edge and sampled on the trailing edge.
- R5: When `cfg_wide`=1, a character is 16 bits, and bit 15 of the shift register is sent first.
- R6: If a transfer starts without a new character having been loaded, the slave sends the character it received in the previous transfer.
- R7: If `ssn_in` rises before the last bit of a character, the transfer is aborted. `rd_buf` and `done_flag` keep their values, and the next full transfer is received correctly.
- R8: When a character completes, `done_flag` becomes 1. `irq` equals `done_flag` AND `irq_en`.
- R9: A one-cycle pulse on `flag_clr` clears `done_flag` to 0.
- R10: A pulse on `wr_en` while the slave is selected is ignored. Both the character being sent and the echo in the next transfer are unaffected.
- R11: When `cfg_wide`=0, a character is 8 bits. Bit 7 is sent first, and `rd_buf[15:8]` is loaded as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_wide | input | 1 | 1: 16-bit characters; 0: 8-bit characters |
| irq_en | input | 1 | Interrupt enable |
| wr_en | input | 1 | Load strobe for the shift register (honoured only when deselected) |
| wr_data | input | 16 | Character to transmit |
| flag_clr | input | 1 | Write-one clear of the completion flag |
| sclk_in | input | 1 | Serial clock from the master (asynchronous) |
| mosi_in | input | 1 | Serial data from the master (asynchronous) |
| ssn_in | input | 1 | Active-low slave select (asynchronous) |
| miso_o | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for `miso_o` |
| rd_buf | output | 16 | Last completed received character |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |

## Verification
Some rules are checked by assertions on every cycle:
- the bit counter starts at zero on each select and never reaches the character length;
- the read buffer changes only on a completion pulse;
- the shift register holds while deselected and not being loaded;
- a completion pulse always sets the flag, and a clear pulse without a completion pulse always clears it.

Other behaviour can only be shown by the bench's scenarios. These are the bit order seen by the master in each of the four modes, the echo of the last received character, the recovery after an aborted character, and the rejection of a load while selected. The bench runs a seeded random mix of modes, widths and characters, with directed cases added for abort, a mid-transfer load, clock activity while idle, and the 8-bit zero fill.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

    localparam int WORD_W   = 16;
    localparam int NARROW_W = 8;
    localparam int SYNC_N   = 2;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic wide;
    } spi_cfg_t;

    typedef struct packed {
        logic sclk;
        logic mosi;
        logic ssn;
    } spi_pins_t;

    typedef struct packed {
        logic sample;
        logic shift;
    } spi_evt_t;

    // leading edge moves the clock away from its idle level
    function automatic logic lead_edge(logic cpol, logic rise, logic fall);
        return cpol ? fall : rise;
    endfunction

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
    parameter int W       = 3,
    parameter int STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stg
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_slv_edge.sv
module spi_slv_edge
    import spi_slv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk_s,
    input  logic     active,
    input  spi_cfg_t cfg,
    output spi_evt_t evt
);
    logic sclk_q;
    logic rise, fall, lead, trail;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk_s;
    end

    always_comb begin
        rise  = sclk_s & ~sclk_q;
        fall  = ~sclk_s & sclk_q;
        lead  = lead_edge(cfg.cpol, rise, fall);
        trail = lead_edge(cfg.cpol, fall, rise);
        evt.sample = active & (cfg.cpha ? trail : lead);
        evt.shift  = active & (cfg.cpha ? lead  : trail);
    end
endmodule

// File: rtl/spi_slv_shreg.sv
module spi_slv_shreg #(
    parameter int WORD_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              wide,
    input  logic              sample,
    input  logic              shift,
    input  logic              mosi,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              tx_bit,
    output logic              done_pulse,
    output logic [WORD_W-1:0] rd_buf
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [WORD_W-1:0] LOW_MASK = {{(WORD_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic [WORD_W-1:0] sr, nxt;
    logic [CNT_W-1:0]  cnt, len;
    logic              pend, rx_bit, last;

    assign len    = wide ? CNT_W'(WORD_W) : CNT_W'(NARROW_W);
    assign last   = sample && (cnt == len - CNT_W'(1));
    assign nxt    = {sr[WORD_W-2:0], mosi};
    assign tx_bit = wide ? sr[WORD_W-1] : sr[NARROW_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr         <= '0;
            cnt        <= '0;
            pend       <= 1'b0;
            rx_bit     <= 1'b0;
            rd_buf     <= '0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            if (!active) begin
                cnt  <= '0;
                pend <= 1'b0;
                if (wr_en) sr <= wr_data;
            end else if (last) begin
                sr         <= nxt;
                rd_buf     <= wide ? nxt : (nxt & LOW_MASK);
                cnt        <= '0;
                pend       <= 1'b0;
                done_pulse <= 1'b1;
            end else if (sample) begin
                rx_bit <= mosi;
                pend   <= 1'b1;
                cnt    <= cnt + CNT_W'(1);
            end else if (shift && pend) begin
                sr   <= {sr[WORD_W-2:0], rx_bit};
                pend <= 1'b0;
            end
        end
    end

    AST_CNT_FRESH: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> (cnt == '0)); // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt < len); // R5
    AST_BUF_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        !$stable(rd_buf) |-> done_pulse); // R7
    AST_SR_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!active && !wr_en) |=> $stable(sr)); // R2
endmodule

// File: rtl/spi_slv_core.sv
module spi_slv_core
    import spi_slv_pkg::*;
#(
    parameter int DATA_W   = WORD_W,
    parameter int SHORT_W  = NARROW_W,
    parameter int SYNC_LEN = SYNC_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_wide,
    input  logic              irq_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flag_clr,
    input  logic              sclk_in,
    input  logic              mosi_in,
    input  logic              ssn_in,
    output logic              miso_o,
    output logic              miso_oe,
    output logic [DATA_W-1:0] rd_buf,
    output logic              done_flag,
    output logic              irq
);
    spi_pins_t raw, syn;
    spi_cfg_t  cfg;
    spi_evt_t  evt;
    logic      active, tx_bit, done_pulse;

    assign raw = '{sclk: sclk_in, mosi: mosi_in, ssn: ssn_in};
    assign cfg = '{cpol: cfg_cpol, cpha: cfg_cpha, wide: cfg_wide};

    spi_slv_sync #(.W(3), .STAGES(SYNC_LEN), .RST_VAL(3'b001)) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(syn)
    );

    assign active = ~syn.ssn;

    spi_slv_edge u_edge (
        .clk(clk), .rst(rst), .sclk_s(syn.sclk), .active(active),
        .cfg(cfg), .evt(evt)
    );

    spi_slv_shreg #(.WORD_W(DATA_W), .NARROW_W(SHORT_W)) u_shreg (
        .clk(clk), .rst(rst), .active(active), .wide(cfg.wide),
        .sample(evt.sample), .shift(evt.shift), .mosi(syn.mosi),
        .wr_en(wr_en), .wr_data(wr_data), .tx_bit(tx_bit),
        .done_pulse(done_pulse), .rd_buf(rd_buf)
    );

    always_ff @(posedge clk) begin
        if (rst)             done_flag <= 1'b0;
        else if (done_pulse) done_flag <= 1'b1;
        else if (flag_clr)   done_flag <= 1'b0;
    end

    assign miso_oe = active;
    assign miso_o  = active & tx_bit;
    assign irq     = done_flag & irq_en;

    AST_DONE_SETS: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> done_flag); // R8
    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !done_pulse) |=> !done_flag); // R9
endmodule

// File: tb/spi_slv_core_test.sv
module spi_slv_core_test;
    localparam int CLK_PER = 10;

    logic clk = 0, rst = 1;
    logic cpol = 0, cpha = 0, wide = 0, irq_en = 0;
    logic wr_en = 0, flag_clr = 0;
    logic [15:0] wr_data = '0;
    logic sclk = 0, mosi = 0, ssn = 1;
    logic miso, miso_oe, done_flag, irq;
    logic [15:0] rd_buf;
    int n_chk = 0, n_err = 0;

    always #(CLK_PER/2) clk = ~clk;

    spi_slv_core uut (
        .clk(clk), .rst(rst), .cfg_cpol(cpol), .cfg_cpha(cpha), .cfg_wide(wide),
        .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data), .flag_clr(flag_clr),
        .sclk_in(sclk), .mosi_in(mosi), .ssn_in(ssn), .miso_o(miso),
        .miso_oe(miso_oe), .rd_buf(rd_buf), .done_flag(done_flag), .irq(irq)
    );

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] fit(input logic w, input logic [15:0] v);
        return w ? v : {8'h00, v[7:0]};
    endfunction

    task automatic set_mode(input logic p, input logic h, input logic w);
        cpol = p; cpha = h; wide = w; sclk = p;
        waitc(6);
    endtask

    task automatic load(input logic [15:0] v);
        wr_data = v; wr_en = 1; waitc(1); wr_en = 0; waitc(1);
    endtask

    task automatic clear_flag();
        flag_clr = 1; waitc(1); flag_clr = 0; waitc(1);
    endtask

    task automatic xfer(input int nsend, input logic [15:0] mtx, input logic mid,
                        output logic [15:0] mrx, output logic oe_seen);
        int nb;
        nb = wide ? 16 : 8;
        mrx = '0;
        ssn = 0;
        waitc(8);
        oe_seen = miso_oe;
        for (int k = 0; k < nsend; k++) begin
            logic b;
            b = mtx[nb-1-k];
            if (!cpha) begin
                mosi = b; waitc(8);
                mrx = {mrx[14:0], miso};
                sclk = ~cpol; waitc(8);
                sclk = cpol;
            end else begin
                sclk = ~cpol; mosi = b; waitc(8);
                mrx = {mrx[14:0], miso};
                sclk = cpol; waitc(8);
            end
            if (mid && k == nb/2) begin
                wr_data = 16'hFFFF; wr_en = 1; waitc(1); wr_en = 0;
            end
        end
        waitc(8);
        ssn = 1;
        waitc(10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] rx, prev_buf, mt, tv;
        logic oe;
        void'($urandom(32'd4711));
        waitc(3);
        rst = 0;
        waitc(2);
        // R1 reset state
        chk("R1 oe", {15'd0, miso_oe}, 16'd0);
        chk("R1 flag", {15'd0, done_flag}, 16'd0);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 rd_buf", rd_buf, 16'h0000);

        // R2 clock activity while deselected
        for (int i = 0; i < 24; i++) begin
            sclk = ~sclk; mosi = $urandom(); waitc(8);
        end
        sclk = 0; waitc(6);
        chk("R2 oe idle", {15'd0, miso_oe}, 16'd0);
        chk("R2 rd_buf", rd_buf, 16'h0000);
        chk("R2 flag", {15'd0, done_flag}, 16'd0);

        // R3 / R8 basic mode 0, 8-bit
        irq_en = 1;
        set_mode(0, 0, 0);
        load(16'h00A5);
        xfer(8, 16'h003C, 0, rx, oe);
        chk("R2 oe active", {15'd0, oe}, 16'd1);
        chk("R3 miso", rx & 16'h00FF, 16'h00A5);
        chk("R3 rd_buf", rd_buf, 16'h003C);
        chk("R8 flag", {15'd0, done_flag}, 16'd1);
        chk("R8 irq", {15'd0, irq}, 16'd1);
        irq_en = 0; waitc(1);
        chk("R8 irq masked", {15'd0, irq}, 16'd0);
        irq_en = 1;
        clear_flag();
        chk("R9 clear", {15'd0, done_flag}, 16'd0);

        // R6 echo without reload
        xfer(8, 16'h0081, 0, rx, oe);
        chk("R6 echo", rx & 16'h00FF, 16'h003C);
        chk("R3 rd_buf 2", rd_buf, 16'h0081);
        clear_flag();

        // R7 abort
        prev_buf = rd_buf;
        load(16'h005A);
        xfer(5, 16'h00F0, 0, rx, oe);
        chk("R7 flag kept", {15'd0, done_flag}, 16'd0);
        chk("R7 buf kept", rd_buf, prev_buf);
        load(16'h00C3);
        xfer(8, 16'h0067, 0, rx, oe);
        chk("R7 recover tx", rx & 16'h00FF, 16'h00C3);
        chk("R7 recover rx", rd_buf, 16'h0067);
        clear_flag();

        // R10 load while selected ignored
        load(16'h0096);
        xfer(8, 16'h0011, 1, rx, oe);
        chk("R10 tx unaffected", rx & 16'h00FF, 16'h0096);
        xfer(8, 16'h0022, 0, rx, oe);
        chk("R10 echo unaffected", rx & 16'h00FF, 16'h0011);
        clear_flag();

        // R11 narrow mode zero fill
        set_mode(0, 0, 1);
        load(16'hFFFF);
        xfer(16, 16'hFFFF, 0, rx, oe);
        set_mode(1, 1, 0);
        load(16'hBEEF);
        xfer(8, 16'h0012, 0, rx, oe);
        chk("R11 tx low byte", rx & 16'h00FF, 16'h00EF);
        chk("R11 rd_buf", rd_buf, 16'h0012);
        clear_flag();

        // R4 / R5 all modes, 16-bit
        for (int m = 0; m < 4; m++) begin
            set_mode(m[1], m[0], 1);
            load(16'h1234 + 16'(m));
            xfer(16, 16'hABCD ^ 16'(m), 0, rx, oe);
            chk($sformatf("R4 R5 mode%0d tx", m), rx, 16'h1234 + 16'(m));
            chk($sformatf("R4 R5 mode%0d rx", m), rd_buf, 16'hABCD ^ 16'(m));
            clear_flag();
        end

        // random mix
        for (int i = 0; i < 40; i++) begin
            logic [2:0] r;
            r = 3'($urandom());
            set_mode(r[2], r[1], r[0]);
            tv = 16'($urandom());
            mt = 16'($urandom());
            load(tv);
            xfer(r[0] ? 16 : 8, mt, 0, rx, oe);
            chk("R3 R4 random tx", fit(r[0], rx), fit(r[0], tv));
            chk("R3 R11 random rx", rd_buf, fit(r[0], mt));
            chk("R8 random flag", {15'd0, done_flag}, 16'd1);
            clear_flag();
            chk("R9 random clear", {15'd0, done_flag}, 16'd0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule